// File: doc/BRIEF.md
# Look-Up-Table Distributed RAM Element

This block is a one-bit-wide memory built from small look-up-table banks of sixteen words each. Port A writes on the rising edge of `clk` when `wr_en` is high and reads the same location it addresses. Port B has its own address and only reads, so the element can serve as a single-port 16x1 store, a 16x1 dual-port store, or a 32x1 store made of two cascaded banks.

`deep_mode` selects the depth. When it is high, the top address bit chooses the bank for both the write and the reads. When it is low, only bank 0 is used and the top address bit has no effect. Each read output can be combinational or registered. `a_sync` and `b_sync` each select the output flop for their port. The flop takes the combinational read value on every clock edge, the same edge that performs writes. This makes a synchronous read possible without an extra pipeline stage elsewhere.

Top module: `lut_dram`

## Requirements
- R1: With `deep_mode`=1 all 32 addresses `{addr[4], addr[3:0]}` hold independent one-bit words that read back as written.
- R2: A location changes only on a rising `clk` edge with `wr_en`=1. With `wr_en`=0 a toggling `din` leaves every word unchanged.
- R3: With `deep_mode`=0, address bit 4 is ignored on both ports. Writes land in bank 0 at `addr[3:0]`, and the words at addresses 16..31 keep their contents.
- R4: With `a_sync`=0, `a_dout` is the word at the effective `a_addr`, combinationally and without waiting for a clock.
- R5: With `b_sync`=0, `b_dout` is the word at the effective `b_addr`, independent of `a_addr`.
- R6: When `a_addr` and `b_addr` name the same word during a write, both combinational outputs show the new data right after the writing edge.
- R7: With `a_sync`=1 (or `b_sync`=1), the output equals the combinational read value from just before the most recent rising edge, including the old data on a writing edge.
- R8: With `deep_mode`=1, `a_addr[4]` selects the bank that is written and the bank that port A reads. `b_addr[4]` selects the bank that port B reads.
- R9: At most one bank is written per edge, and only when `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and output-register clock |
| wr_en | input | 1 | Write enable for port A |
| din | input | 1 | Write data |
| deep_mode | input | 1 | 1: 32x1 cascaded banks, 0: 16x1 in bank 0 |
| a_sync | input | 1 | 1: registered port A output |
| b_sync | input | 1 | 1: registered port B output |
| a_addr | input | 5 | Port A read/write address |
| b_addr | input | 5 | Port B read address |
| a_dout | output | 1 | Port A read data |
| b_dout | output | 1 | Port B read data |

## Verification
A write and a read of the same word can fall in the same cycle, both at port A and at port B through a matching address. The bench drives equal addresses with an inverted data bit. It first checks the old value before the edge and then the new value just after the edge on the combinational outputs. With the output registers selected, the bench repeats the collision and expects the old value after the writing edge and the new value one edge later.

// File: rtl/lut_dram_pkg.sv
package lut_dram_pkg;
  // Effective word index: in shallow mode the bank-select bits are forced to zero.
  function automatic int unsigned eff_index(input int unsigned addr, input logic deep,
                                            input int unsigned bank_aw);
    int unsigned low_mask;
    low_mask = (32'd1 << bank_aw) - 32'd1;
    return deep ? addr : (addr & low_mask);
  endfunction

  // Bank number carried in the upper bits of an effective index.
  function automatic int unsigned bank_of(input int unsigned idx, input int unsigned bank_aw);
    return idx >> bank_aw;
  endfunction
endpackage

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic          din,
  input  logic [AW-1:0] wa,
  input  logic [AW-1:0] ra2,
  output logic          rd1,
  output logic          rd2
);
  localparam int unsigned WORDS = 1 << AW;

  logic [WORDS-1:0] cells;

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= din;
  end

  assign rd1 = cells[wa];
  assign rd2 = cells[ra2];
endmodule

// File: rtl/read_stage.sv
module read_stage (
  input  logic clk,
  input  logic sync,
  input  logic d,
  output logic q_out
);
  logic held;

  always_ff @(posedge clk) held <= d;

  assign q_out = sync ? held : d;
endmodule

// File: rtl/lut_dram.sv
module lut_dram #(
  parameter int unsigned BANK_AW = 4,
  parameter int unsigned SEL_W   = 1
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic                     din,
  input  logic                     deep_mode,
  input  logic                     a_sync,
  input  logic                     b_sync,
  input  logic [BANK_AW+SEL_W-1:0] a_addr,
  input  logic [BANK_AW+SEL_W-1:0] b_addr,
  output logic                     a_dout,
  output logic                     b_dout
);
  import lut_dram_pkg::*;

  localparam int unsigned NB  = 1 << SEL_W;
  localparam int unsigned TAW = BANK_AW + SEL_W;

  logic [TAW-1:0]   a_eff, b_eff;
  logic [SEL_W-1:0] a_bank, b_bank;
  logic [NB-1:0]    bank_we;
  logic [NB-1:0]    a_rd, b_rd;
  logic             a_comb, b_comb;

  assign a_eff  = TAW'(eff_index(32'(a_addr), deep_mode, BANK_AW));
  assign b_eff  = TAW'(eff_index(32'(b_addr), deep_mode, BANK_AW));
  assign a_bank = SEL_W'(bank_of(32'(a_eff), BANK_AW));
  assign b_bank = SEL_W'(bank_of(32'(b_eff), BANK_AW));

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign bank_we[g] = wr_en && (a_bank == SEL_W'(g));
    lut_bank #(.AW(BANK_AW)) u_bank (
      .clk (clk),
      .we  (bank_we[g]),
      .din (din),
      .wa  (a_eff[BANK_AW-1:0]),
      .ra2 (b_eff[BANK_AW-1:0]),
      .rd1 (a_rd[g]),
      .rd2 (b_rd[g])
    );
  end

  assign a_comb = a_rd[a_bank];
  assign b_comb = b_rd[b_bank];

  read_stage u_a_out (.clk(clk), .sync(a_sync), .d(a_comb), .q_out(a_dout));
  read_stage u_b_out (.clk(clk), .sync(b_sync), .d(b_comb), .q_out(b_dout));
endmodule

// File: rtl/lut_dram_chk.sv
module lut_dram_chk #(
  parameter int unsigned BANK_AW = 4,
  parameter int unsigned SEL_W   = 1
) (
  input logic                     clk,
  input logic                     wr_en,
  input logic                     din,
  input logic                     deep_mode,
  input logic                     a_sync,
  input logic                     b_sync,
  input logic [BANK_AW+SEL_W-1:0] a_eff,
  input logic [BANK_AW+SEL_W-1:0] b_eff,
  input logic [(1<<SEL_W)-1:0]    bank_we,
  input logic                     a_comb,
  input logic                     b_comb,
  input logic                     a_dout,
  input logic                     b_dout
);
  localparam int unsigned NB = 1 << SEL_W;

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  // R9: one bank at most, and only with write enable
  assert_one_bank_R9: assert property (@(posedge clk) disable iff (!primed)
    $onehot0(bank_we) && ((|bank_we) == wr_en));

  // R3: shallow mode never touches upper banks
  assert_shallow_bank0_R3: assert property (@(posedge clk) disable iff (!primed)
    !deep_mode |-> (bank_we[NB-1:1] == '0));

  // R6: matching read address shows the freshly written bit
  assert_collision_new_R6: assert property (@(posedge clk) disable iff (!primed)
    wr_en |=> ((b_eff == $past(a_eff)) -> (b_comb == $past(din))));

  // R2: without a write the addressed word holds still
  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!primed)
    !wr_en |=> ($stable(b_eff) -> $stable(b_comb)));

  // R7: registered outputs carry the pre-edge read value
  assert_a_registered_R7: assert property (@(posedge clk) disable iff (!primed)
    a_sync && $past(a_sync) |-> (a_dout == $past(a_comb)));
  assert_b_registered_R7: assert property (@(posedge clk) disable iff (!primed)
    b_sync && $past(b_sync) |-> (b_dout == $past(b_comb)));
endmodule

bind lut_dram lut_dram_chk #(.BANK_AW(BANK_AW), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .wr_en(wr_en), .din(din), .deep_mode(deep_mode),
  .a_sync(a_sync), .b_sync(b_sync), .a_eff(a_eff), .b_eff(b_eff),
  .bank_we(bank_we), .a_comb(a_comb), .b_comb(b_comb),
  .a_dout(a_dout), .b_dout(b_dout)
);

// File: tb/sim_lut_dram.sv
module sim_lut_dram;
  logic clk = 1'b0;
  logic wr_en = 1'b0, din = 1'b0, deep_mode = 1'b1, a_sync = 1'b0, b_sync = 1'b0;
  logic [4:0] a_addr = '0, b_addr = '0;
  logic a_dout, b_dout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit ref_mem [32];

  always #4 clk = ~clk;

  lut_dram u0 (
    .clk(clk), .wr_en(wr_en), .din(din), .deep_mode(deep_mode),
    .a_sync(a_sync), .b_sync(b_sync), .a_addr(a_addr), .b_addr(b_addr),
    .a_dout(a_dout), .b_dout(b_dout)
  );

  function automatic int widx(int addr, bit deep);
    return deep ? addr : addr % 16;
  endfunction

  function automatic bit pat(int i);
    return bit'(((i * 7) >> 1) & 1) ^ bit'((i >> 4) & 1);
  endfunction

  task automatic check(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b (a=%0d b=%0d)", req, got, exp, a_addr, b_addr);
    end
  endtask

  task automatic wr(int addr, bit d);
    a_addr = 5'(addr); din = d; wr_en = 1'b1;
    @(posedge clk);
    ref_mem[widx(addr, deep_mode)] = d;
    #1 wr_en = 1'b0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // reset-state: clear all words, then read back zeros
    for (int i = 0; i < 32; i++) wr(i, 1'b0);
    for (int i = 0; i < 32; i++) begin
      a_addr = 5'(i); b_addr = 5'(31 - i); #1;
      check("R1 cleared", a_dout, 1'b0);
      check("R5 cleared", b_dout, 1'b0);
    end
    // deep mode pattern, full sweep of address pairs
    for (int i = 0; i < 32; i++) wr(i, pat(i));
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) begin
        a_addr = 5'(i); b_addr = 5'(j); #1;
        check("R4 deep read", a_dout, ref_mem[i]);
        check("R5 deep read", b_dout, ref_mem[j]);
      end
    // shallow mode: upper addresses alias into bank 0
    deep_mode = 1'b0;
    for (int i = 16; i < 32; i++) wr(i, ~pat(i));
    for (int i = 0; i < 32; i++) begin
      a_addr = 5'(i); b_addr = 5'(i ^ 16); #1;
      check("R3 shallow A", a_dout, ref_mem[i % 16]);
      check("R3 shallow B", b_dout, ref_mem[i % 16]);
    end
    deep_mode = 1'b1;
    for (int i = 16; i < 32; i++) begin
      a_addr = 5'(i); b_addr = 5'(i - 16); #1;
      check("R3 bank1 kept", a_dout, pat(i));
      check("R8 bank0 word", b_dout, ref_mem[i - 16]);
    end
    // write enable low: din toggles, nothing changes
    for (int i = 0; i < 32; i++) begin
      a_addr = 5'(i); b_addr = 5'(i); din = ~ref_mem[i];
      @(posedge clk); #1;
      check("R2 no write A", a_dout, ref_mem[i]);
      check("R2 no write B", b_dout, ref_mem[i]);
    end
    // collision on combinational outputs
    for (int i = 0; i < 32; i += 5) begin
      bit old_v;
      old_v = ref_mem[i];
      b_addr = 5'(i); a_addr = 5'(i); din = ~old_v; #1;
      check("R6 before edge", b_dout, old_v);
      wr(i, ~old_v);
      check("R6 new on B", b_dout, ~old_v);
      check("R6 new on A", a_dout, ~old_v);
    end
    // registered outputs
    a_sync = 1'b1; b_sync = 1'b1;
    a_addr = 5'd3; b_addr = 5'd20;
    @(posedge clk); #1;
    check("R7 A loaded", a_dout, ref_mem[3]);
    check("R7 B loaded", b_dout, ref_mem[20]);
    a_addr = 5'd6; b_addr = 5'd27; #1;
    check("R7 A held", a_dout, ref_mem[3]);
    check("R7 B held", b_dout, ref_mem[20]);
    @(posedge clk); #1;
    check("R7 A updated", a_dout, ref_mem[6]);
    check("R7 B updated", b_dout, ref_mem[27]);
    for (int i = 9; i < 32; i += 11) begin
      bit old_v;
      old_v = ref_mem[i];
      b_addr = 5'(i);
      wr(i, ~old_v);
      check("R7 A old on write edge", a_dout, old_v);
      check("R7 B old on write edge", b_dout, old_v);
      @(posedge clk); #1;
      check("R7 A new next edge", a_dout, ~old_v);
      check("R6 B new next edge", b_dout, ~old_v);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule